// File: doc/BRIEF.md
# Interrupt presenter register port

This block is the register window that one hardware thread uses to talk to its interrupt presenter. A simple memory-mapped bus reaches it with an address, a byte count, a read strobe, a write strobe and 32-bit data. Each access is decoded by the word it selects and by its width, and the matching action is applied to a small presenter state. That state holds a current priority, one pending source with its priority, a software interrupt priority and a set of general link words. The thread is interrupted while a pending source is more favoured than the current priority.

The same word offset does different things depending on access width. A word read at the accept offset hands over the pending interrupt and raises the current priority to match it. A byte read at that offset only reports the current priority. Word layout is big-endian: byte 0 of a word is bits [31:24], and so a byte read of the word at offset 0 returns the current priority. A byte travels in bits [7:0] of the data bus. Read data is combinational and is valid in the cycle the read strobe is high. State changes take effect at the clock edge that ends that cycle. A one-cycle source request input stands in for the interrupt source side.

Top module: `intp_mmio_port`

## Requirements
- R1: Only address bits [11:2] select the register. Word 0 is the status view, word 1 is accept/priority, word 3 is the software request, and words 4, 5 and 6 are link words 0 to 2. A 4-byte access is honoured whatever the value of address bits [1:0].
- R2: A byte access (bus_len=1) is honoured only when address bits [1:0] are zero. Any other byte access, and any bus_len other than 1 or 4, is a bad access.
- R3: At word 0, a word read returns {current priority[31:24], pending source[23:0]} and a byte read returns the current priority in bits [7:0]. Neither changes any state. Any write to word 0 is a bad access.
- R4: At word 1, a byte read returns the current priority and has no effect. A word read returns the status word as it was before the access, then accepts: if the pending source is nonzero, the current priority takes the pending priority. The pending source becomes 0 and the pending priority becomes 0xFF.
- R5: At word 1, a byte write loads the current priority from data bits [7:0]. A word write ends the interrupt by loading the current priority from data bits [31:24].
- R6: Word 3 is reached only with byte accesses and stores an 8-bit request priority. When a written value is lower than both the current priority and the pending priority, source 2 becomes pending at that priority.
- R7: Link words are reached only with word accesses. Each one stores the 32-bit value written to it and returns it on a read.
- R8: A bad access, an access to an unmapped word, a cycle with no read, and a cycle with both strobes high all return 0xFFFFFFFF on bus_rdata and change no state.
- R9: A source request with a nonzero id and a priority lower than the pending priority replaces the pending source. Any other request is ignored. The request is applied after the bus action of the same cycle.
- R10: irq_o is high exactly while the pending source is nonzero and the pending priority is numerically lower than the current priority.
- R11: After reset the current priority is 0x00, the pending source is 0, the pending priority is 0xFF, the request priority is 0xFF, the link words are 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Byte address inside the 4 KB window |
| bus_len | input | 3 | Access size in bytes (1 or 4 are meaningful) |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data, big-endian word, byte in [7:0] |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| src_req | input | 1 | Source offers an interrupt this cycle |
| src_id | input | 24 | Offered source number |
| src_prio | input | 8 | Offered priority |
| irq_o | output | 1 | Interrupt request to the thread |

## Verification
The bench builds the port with its defaults: a 12-bit window, 8-bit priorities, 24-bit source numbers, three link words and source number 2 for software requests. At these sizes every mapped word, each gap between them, unaligned byte and word addresses, and the odd byte counts 2 and 3 can all be driven directly. The 8-bit priorities let the walk place the current, pending and request priorities on either side of one another. This covers the posting, masking, accept and end-of-interrupt orderings, as well as an accept that coincides with a new source.

// File: rtl/intp_pkg.sv
package intp_pkg;

  // One decoded action per bus cycle
  typedef enum logic [3:0] {
    OP_IDLE,
    OP_BAD,
    OP_RD_STATUS,
    OP_RD_PRIO,
    OP_RD_ACCEPT,
    OP_RD_SWREQ,
    OP_RD_LINK,
    OP_WR_PRIO,
    OP_WR_EOI,
    OP_WR_SWREQ,
    OP_WR_LINK
  } intp_op_e;

  localparam int unsigned LEN_BYTE = 1;
  localparam int unsigned LEN_WORD = 4;

  // Word indices whose placement the software side relies on
  localparam int unsigned IDX_STATUS = 0;
  localparam int unsigned IDX_ACCEPT = 1;
  localparam int unsigned IDX_SWREQ  = 3;
  localparam int unsigned IDX_LINK0  = 4;

endpackage

// File: rtl/intp_decode.sv
module intp_decode
  import intp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned LEN_W     = 3,
  parameter int unsigned NUM_LINKS = 3,
  parameter int unsigned LSEL_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic              rd,
  input  logic              wr,
  output intp_op_e          op,
  output logic [LSEL_W-1:0] link_sel
);

  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_STATUS = IDX_W'(IDX_STATUS);
  localparam logic [IDX_W-1:0] I_ACCEPT = IDX_W'(IDX_ACCEPT);
  localparam logic [IDX_W-1:0] I_SWREQ  = IDX_W'(IDX_SWREQ);

  logic [IDX_W-1:0] idx;
  logic             is_byte;
  logic             is_word;
  logic             link_hit;

  assign idx     = addr[ADDR_W-1:2];
  assign is_byte = (len == LEN_W'(LEN_BYTE)) && (addr[1:0] == 2'b00);
  assign is_word = (len == LEN_W'(LEN_WORD));

  always_comb begin
    link_hit = 1'b0;
    link_sel = '0;
    for (int i = 0; i < NUM_LINKS; i++) begin
      if (idx == IDX_W'(IDX_LINK0 + i)) begin
        link_hit = 1'b1;
        link_sel = LSEL_W'(i);
      end
    end
  end

  always_comb begin
    op = OP_IDLE;
    if (rd && !wr) begin
      op = OP_BAD;
      if (idx == I_STATUS) begin
        if (is_word)      op = OP_RD_STATUS;
        else if (is_byte) op = OP_RD_PRIO;
      end else if (idx == I_ACCEPT) begin
        if (is_word)      op = OP_RD_ACCEPT;
        else if (is_byte) op = OP_RD_PRIO;
      end else if (idx == I_SWREQ) begin
        if (is_byte)      op = OP_RD_SWREQ;
      end else if (link_hit && is_word) begin
        op = OP_RD_LINK;
      end
    end else if (wr && !rd) begin
      op = OP_BAD;
      if (idx == I_ACCEPT) begin
        if (is_word)      op = OP_WR_EOI;
        else if (is_byte) op = OP_WR_PRIO;
      end else if (idx == I_SWREQ) begin
        if (is_byte)      op = OP_WR_SWREQ;
      end else if (link_hit && is_word) begin
        op = OP_WR_LINK;
      end
    end
  end

endmodule

// File: rtl/intp_core.sv
module intp_core
  import intp_pkg::*;
#(
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned SRC_W   = 24,
  parameter int unsigned IPI_SRC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  intp_op_e          op,
  input  logic [PRIO_W-1:0] wr_lo,
  input  logic [PRIO_W-1:0] wr_hi,
  input  logic              src_req,
  input  logic [SRC_W-1:0]  src_id,
  input  logic [PRIO_W-1:0] src_prio,
  output logic [PRIO_W-1:0] cur_prio,
  output logic [SRC_W-1:0]  pend_src,
  output logic [PRIO_W-1:0] pend_prio,
  output logic [PRIO_W-1:0] swreq_prio
);

  localparam logic [SRC_W-1:0] SW_SRC = SRC_W'(IPI_SRC);

  logic [PRIO_W-1:0] cur_q, cur_n;
  logic [SRC_W-1:0]  src_q, src_n;
  logic [PRIO_W-1:0] pp_q, pp_n;
  logic [PRIO_W-1:0] sw_q, sw_n;
  logic              bus_mod;
  logic              take_src;
  logic              upd_en;

  always_comb begin
    cur_n   = cur_q;
    src_n   = src_q;
    pp_n    = pp_q;
    sw_n    = sw_q;
    bus_mod = 1'b1;
    case (op)
      OP_RD_ACCEPT: begin
        if (src_q != '0) cur_n = pp_q;
        src_n = '0;
        pp_n  = '1;
      end
      OP_WR_PRIO: cur_n = wr_lo;
      OP_WR_EOI:  cur_n = wr_hi;
      OP_WR_SWREQ: begin
        sw_n = wr_lo;
        if ((wr_lo < cur_q) && (wr_lo < pp_q)) begin
          src_n = SW_SRC;
          pp_n  = wr_lo;
        end
      end
      default: bus_mod = 1'b0;
    endcase
    // source side is merged after the bus action of the same cycle
    take_src = src_req && (src_id != '0) && (src_prio < pp_n);
    if (take_src) begin
      src_n = src_id;
      pp_n  = src_prio;
    end
    upd_en = bus_mod || take_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      src_q <= '0;
      pp_q  <= '1;
      sw_q  <= '1;
    end else if (upd_en) begin
      cur_q <= cur_n;
      src_q <= src_n;
      pp_q  <= pp_n;
      sw_q  <= sw_n;
    end
  end

  assign cur_prio   = cur_q;
  assign pend_src   = src_q;
  assign pend_prio  = pp_q;
  assign swreq_prio = sw_q;

endmodule

// File: rtl/intp_links.sv
module intp_links #(
  parameter int unsigned NUM_LINKS = 3,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LSEL_W    = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [LSEL_W-1:0]                 sel,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [NUM_LINKS-1:0][DATA_W-1:0]  link_q
);

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
    logic              en;
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_n;

    assign en     = wr_en && (sel == LSEL_W'(g));
    assign word_n = wdata;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= '0;
      else if (en) word_q <= word_n;
    end

    assign link_q[g] = word_q;
  end

endmodule

// File: rtl/intp_rdmux.sv
module intp_rdmux
  import intp_pkg::*;
#(
  parameter int unsigned PRIO_W    = 8,
  parameter int unsigned SRC_W     = 24,
  parameter int unsigned NUM_LINKS = 3,
  parameter int unsigned LSEL_W    = 2
) (
  input  intp_op_e                                  op,
  input  logic [PRIO_W-1:0]                         cur_prio,
  input  logic [SRC_W-1:0]                          pend_src,
  input  logic [PRIO_W-1:0]                         swreq_prio,
  input  logic [NUM_LINKS-1:0][PRIO_W+SRC_W-1:0]    link_q,
  input  logic [LSEL_W-1:0]                         link_sel,
  output logic [PRIO_W+SRC_W-1:0]                   rdata
);

  localparam int unsigned DATA_W = PRIO_W + SRC_W;

  always_comb begin
    case (op)
      OP_RD_STATUS, OP_RD_ACCEPT: rdata = {cur_prio, pend_src};
      OP_RD_PRIO:                 rdata = DATA_W'(cur_prio);
      OP_RD_SWREQ:                rdata = DATA_W'(swreq_prio);
      OP_RD_LINK:                 rdata = link_q[link_sel];
      default:                    rdata = '1;
    endcase
  end

endmodule

// File: rtl/intp_mmio_port.sv
module intp_mmio_port
  import intp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned LEN_W     = 3,
  parameter int unsigned PRIO_W    = 8,
  parameter int unsigned SRC_W     = 24,
  parameter int unsigned NUM_LINKS = 3,
  parameter int unsigned IPI_SRC   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [LEN_W-1:0]        bus_len,
  input  logic                    bus_rd,
  input  logic                    bus_wr,
  input  logic [PRIO_W+SRC_W-1:0] bus_wdata,
  output logic [PRIO_W+SRC_W-1:0] bus_rdata,
  input  logic                    src_req,
  input  logic [SRC_W-1:0]        src_id,
  input  logic [PRIO_W-1:0]       src_prio,
  output logic                    irq_o
);

  localparam int unsigned DATA_W = PRIO_W + SRC_W;
  localparam int unsigned LSEL_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1;

  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  intp_op_e                         op;
  logic [LSEL_W-1:0]                link_sel;
  logic [PRIO_W-1:0]                cur_prio;
  logic [SRC_W-1:0]                 pend_src;
  logic [PRIO_W-1:0]                pend_prio;
  logic [PRIO_W-1:0]                swreq_prio;
  logic [NUM_LINKS-1:0][DATA_W-1:0] link_q;
  logic                             link_wr;

  intp_decode #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NUM_LINKS(NUM_LINKS), .LSEL_W(LSEL_W)
  ) u_decode (
    .addr(bus_addr), .len(bus_len), .rd(bus_rd), .wr(bus_wr),
    .op(op), .link_sel(link_sel)
  );

  intp_core #(
    .PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)
  ) u_core (
    .clk(clk), .rst_n(rst_sync_n), .op(op),
    .wr_lo(bus_wdata[PRIO_W-1:0]),
    .wr_hi(bus_wdata[DATA_W-1 -: PRIO_W]),
    .src_req(src_req), .src_id(src_id), .src_prio(src_prio),
    .cur_prio(cur_prio), .pend_src(pend_src), .pend_prio(pend_prio),
    .swreq_prio(swreq_prio)
  );

  assign link_wr = (op == OP_WR_LINK);

  intp_links #(
    .NUM_LINKS(NUM_LINKS), .DATA_W(DATA_W), .LSEL_W(LSEL_W)
  ) u_links (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(link_wr), .sel(link_sel),
    .wdata(bus_wdata), .link_q(link_q)
  );

  intp_rdmux #(
    .PRIO_W(PRIO_W), .SRC_W(SRC_W), .NUM_LINKS(NUM_LINKS), .LSEL_W(LSEL_W)
  ) u_rdmux (
    .op(op), .cur_prio(cur_prio), .pend_src(pend_src),
    .swreq_prio(swreq_prio), .link_q(link_q), .link_sel(link_sel),
    .rdata(bus_rdata)
  );

  assign irq_o = (pend_src != '0) && (pend_prio < cur_prio);

endmodule

// File: rtl/intp_mmio_chk.sv
module intp_mmio_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned LEN_W  = 3,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned SRC_W  = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [LEN_W-1:0]        bus_len,
  input logic                    bus_rd,
  input logic                    bus_wr,
  input logic [PRIO_W-1:0]       wdata_lo,
  input logic [PRIO_W-1:0]       wdata_hi,
  input logic [PRIO_W+SRC_W-1:0] bus_rdata,
  input logic                    src_req,
  input logic                    irq_o,
  input logic [PRIO_W-1:0]       cur_prio,
  input logic [SRC_W-1:0]        pend_src,
  input logic [PRIO_W-1:0]       pend_prio,
  input logic [PRIO_W-1:0]       swreq_prio
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic rd_only, wr_only, len_bad, word, byte_al;
  logic status_rd, accept_rd, eoi_wr, sw_wr;

  assign idx       = bus_addr[ADDR_W-1:2];
  assign rd_only   = bus_rd && !bus_wr;
  assign wr_only   = bus_wr && !bus_rd;
  assign len_bad   = (bus_len != LEN_W'(1)) && (bus_len != LEN_W'(4));
  assign word      = (bus_len == LEN_W'(4));
  assign byte_al   = (bus_len == LEN_W'(1)) && (bus_addr[1:0] == 2'b00);
  assign status_rd = rd_only && word && (idx == IDX_W'(0));
  assign accept_rd = rd_only && word && (idx == IDX_W'(1));
  assign eoi_wr    = wr_only && word && (idx == IDX_W'(1));
  assign sw_wr     = wr_only && byte_al && (idx == IDX_W'(3));

  assert_status_no_effect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd && !src_req |=> $stable(cur_prio) && $stable(pend_src) && $stable(pend_prio));

  assert_accept_drops_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_rd && !src_req |=> !irq_o && (pend_src == '0));

  assert_eoi_loads_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> cur_prio == $past(wdata_hi));

  assert_swreq_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> swreq_prio == $past(wdata_lo));

  assert_swreq_post_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr && (wdata_lo < cur_prio) && (wdata_lo < pend_prio) |=> irq_o);

  assert_bad_read_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_only && len_bad |-> bus_rdata == '1);

  assert_bad_write_no_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_only && len_bad && !src_req |=> $stable(cur_prio) && $stable(pend_src)
      && $stable(pend_prio) && $stable(swreq_prio));

  assert_idle_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_src == '0) |-> !irq_o);

endmodule

bind intp_mmio_port intp_mmio_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PRIO_W(PRIO_W), .SRC_W(SRC_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_addr(bus_addr), .bus_len(bus_len),
  .bus_rd(bus_rd), .bus_wr(bus_wr),
  .wdata_lo(bus_wdata[PRIO_W-1:0]),
  .wdata_hi(bus_wdata[PRIO_W+SRC_W-1 -: PRIO_W]),
  .bus_rdata(bus_rdata), .src_req(src_req), .irq_o(irq_o),
  .cur_prio(cur_prio), .pend_src(pend_src), .pend_prio(pend_prio),
  .swreq_prio(swreq_prio)
);

// File: tb/intp_mmio_port_bench.sv
`timescale 1ns/1ps
module intp_mmio_port_bench;

  localparam logic [31:0] ONES = 32'hFFFF_FFFF;
  localparam logic [1:0]  K_RD = 2'd0;
  localparam logic [1:0]  K_WR = 2'd1;
  localparam logic [1:0]  K_SR = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [11:0] addr;
    logic [2:0]  len;
    logic [31:0] data;
    logic [31:0] exp;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 46;
  localparam vec_t VEC [NVEC] = '{
    '{K_RD, 12'h000, 3'd4, 32'h0,          32'h0000_0000, 1'b0, 4'd3},  // R3
    '{K_WR, 12'h004, 3'd1, 32'h0000_00FF,  ONES,          1'b0, 4'd5},  // R5
    '{K_RD, 12'h004, 3'd1, 32'h0,          32'h0000_00FF, 1'b0, 4'd4},  // R4
    '{K_RD, 12'h000, 3'd1, 32'h0,          32'h0000_00FF, 1'b0, 4'd3},  // R3
    '{K_SR, 12'h000, 3'd0, 32'h4000_0123,  ONES,          1'b1, 4'd9},  // R9
    '{K_RD, 12'h000, 3'd4, 32'h0,          32'hFF00_0123, 1'b1, 4'd3},  // R3
    '{K_RD, 12'h004, 3'd1, 32'h0,          32'h0000_00FF, 1'b1, 4'd4},  // R4
    '{K_RD, 12'h004, 3'd4, 32'h0,          32'hFF00_0123, 1'b0, 4'd4},  // R4 accept
    '{K_RD, 12'h000, 3'd4, 32'h0,          32'h4000_0000, 1'b0, 4'd4},  // R4
    '{K_WR, 12'h00C, 3'd1, 32'h0000_0010,  ONES,          1'b1, 4'd6},  // R6 post
    '{K_RD, 12'h00C, 3'd1, 32'h0,          32'h0000_0010, 1'b1, 4'd6},  // R6
    '{K_RD, 12'h00C, 3'd4, 32'h0,          ONES,          1'b1, 4'd8},  // R8
    '{K_RD, 12'h000, 3'd4, 32'h0,          32'h4000_0002, 1'b1, 4'd6},  // R6
    '{K_RD, 12'h006, 3'd4, 32'h0,          32'h4000_0002, 1'b0, 4'd1},  // R1
    '{K_RD, 12'h000, 3'd4, 32'h0,          32'h1000_0000, 1'b0, 4'd4},  // R4
    '{K_WR, 12'h004, 3'd4, 32'h4000_0002,  ONES,          1'b0, 4'd5},  // R5 eoi
    '{K_RD, 12'h000, 3'd1, 32'h0,          32'h0000_0040, 1'b0, 4'd5},  // R5
    '{K_WR, 12'h010, 3'd4, 32'hDEAD_BEEF,  ONES,          1'b0, 4'd7},  // R7
    '{K_WR, 12'h014, 3'd4, 32'h1234_5678,  ONES,          1'b0, 4'd7},  // R7
    '{K_WR, 12'h018, 3'd4, 32'hCAFE_F00D,  ONES,          1'b0, 4'd7},  // R7
    '{K_RD, 12'h010, 3'd4, 32'h0,          32'hDEAD_BEEF, 1'b0, 4'd7},  // R7
    '{K_RD, 12'h014, 3'd4, 32'h0,          32'h1234_5678, 1'b0, 4'd7},  // R7
    '{K_RD, 12'h01B, 3'd4, 32'h0,          32'hCAFE_F00D, 1'b0, 4'd1},  // R1
    '{K_RD, 12'h010, 3'd1, 32'h0,          ONES,          1'b0, 4'd7},  // R7
    '{K_WR, 12'h00D, 3'd1, 32'h0000_0005,  ONES,          1'b0, 4'd2},  // R2
    '{K_RD, 12'h00C, 3'd1, 32'h0,          32'h0000_0010, 1'b0, 4'd2},  // R2
    '{K_WR, 12'h004, 3'd2, 32'h0,          ONES,          1'b0, 4'd2},  // R2
    '{K_RD, 12'h004, 3'd1, 32'h0,          32'h0000_0040, 1'b0, 4'd2},  // R2
    '{K_WR, 12'h000, 3'd4, 32'h0,          ONES,          1'b0, 4'd3},  // R3
    '{K_RD, 12'h000, 3'd4, 32'h0,          32'h4000_0000, 1'b0, 4'd3},  // R3
    '{K_RD, 12'h008, 3'd4, 32'h0,          ONES,          1'b0, 4'd8},  // R8
    '{K_RD, 12'h01C, 3'd4, 32'h0,          ONES,          1'b0, 4'd8},  // R8
    '{K_WR, 12'h014, 3'd1, 32'h0,          ONES,          1'b0, 4'd7},  // R7
    '{K_RD, 12'h014, 3'd4, 32'h0,          32'h1234_5678, 1'b0, 4'd7},  // R7
    '{K_WR, 12'h00C, 3'd1, 32'h0000_0050,  ONES,          1'b0, 4'd6},  // R6 no post
    '{K_RD, 12'h000, 3'd4, 32'h0,          32'h4000_0000, 1'b0, 4'd6},  // R6
    '{K_SR, 12'h000, 3'd0, 32'h6000_0077,  ONES,          1'b0, 4'd10}, // R10
    '{K_RD, 12'h000, 3'd4, 32'h0,          32'h4000_0077, 1'b0, 4'd10}, // R10
    '{K_SR, 12'h000, 3'd0, 32'h7000_0099,  ONES,          1'b0, 4'd9},  // R9
    '{K_RD, 12'h000, 3'd4, 32'h0,          32'h4000_0077, 1'b0, 4'd9},  // R9
    '{K_WR, 12'h004, 3'd1, 32'h0000_0080,  ONES,          1'b1, 4'd10}, // R10
    '{K_RD, 12'h003, 3'd3, 32'h0,          ONES,          1'b1, 4'd2},  // R2
    '{K_RD, 12'h000, 3'd1, 32'h0,          32'h0000_0080, 1'b1, 4'd3},  // R3
    '{K_SR, 12'h000, 3'd0, 32'h1000_0000,  ONES,          1'b1, 4'd9},  // R9 id 0
    '{K_RD, 12'h000, 3'd4, 32'h0,          32'h8000_0077, 1'b1, 4'd9},  // R9
    '{K_RD, 12'h00C, 3'd1, 32'h0,          32'h0000_0050, 1'b1, 4'd6}   // R6
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [2:0]  bus_len;
  logic        bus_rd, bus_wr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        src_req;
  logic [23:0] src_id;
  logic [7:0]  src_prio;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  intp_mmio_port u_intp_mmio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_len(bus_len),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_req(src_req), .src_id(src_id),
    .src_prio(src_prio), .irq_o(irq_o)
  );

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_bus();
    bus_addr = '0; bus_len = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_wdata = '0; src_req = 1'b0; src_id = '0; src_prio = '0;
  endtask

  // one strobe cycle: returns read data in that cycle and irq after the edge
  task automatic cycle(input logic rd, input logic wr, input logic [11:0] a,
                       input logic [2:0] l, input logic [31:0] d,
                       input logic sr, input logic [23:0] sid, input logic [7:0] sp,
                       output logic [31:0] rv, output logic iv);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_len = l; bus_wdata = d;
    src_req = sr; src_id = sid; src_prio = sp;
    #1 rv = bus_rdata;
    @(negedge clk);
    idle_bus();
    #1 iv = irq_o;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(11, "irq in reset", {31'b0, irq_o}, 32'h0);
    check(8, "idle rdata in reset", bus_rdata, ONES);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic        iv;
    idle_bus();
    rst_n = 1'b0;
    do_reset();

    // R11 reset values seen through the bus
    cycle(1'b1, 1'b0, 12'h000, 3'd4, 32'h0, 1'b0, 24'h0, 8'h0, rv, iv);
    check(11, "status after reset", rv, 32'h0);
    cycle(1'b1, 1'b0, 12'h00C, 3'd1, 32'h0, 1'b0, 24'h0, 8'h0, rv, iv);
    check(11, "request prio after reset", rv, 32'h0000_00FF);
    cycle(1'b1, 1'b0, 12'h018, 3'd4, 32'h0, 1'b0, 24'h0, 8'h0, rv, iv);
    check(11, "link after reset", rv, 32'h0);
    check(11, "irq after reset", {31'b0, iv}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VEC[i];
      cycle(v.kind == K_RD, v.kind == K_WR, v.addr, v.len, v.data,
            v.kind == K_SR, v.data[23:0], v.data[31:24], rv, iv);
      check(int'(v.req), $sformatf("vector %0d rdata", i), rv, v.exp);
      check(int'(v.req), $sformatf("vector %0d irq", i), {31'b0, iv}, {31'b0, v.irq});
    end

    // R9: accept and a new source in the same cycle (cur 80, pending 77 at 60)
    cycle(1'b1, 1'b0, 12'h004, 3'd4, 32'h0, 1'b1, 24'h000055, 8'h20, rv, iv);
    check(9, "accept value with source", rv, 32'h8000_0077);
    check(9, "irq after accept with source", {31'b0, iv}, 32'h1);
    cycle(1'b1, 1'b0, 12'h000, 3'd4, 32'h0, 1'b0, 24'h0, 8'h0, rv, iv);
    check(9, "status after accept with source", rv, 32'h6000_0055);

    // R8: both strobes together are no access
    cycle(1'b1, 1'b1, 12'h004, 3'd1, 32'h0, 1'b0, 24'h0, 8'h0, rv, iv);
    check(8, "both strobes rdata", rv, ONES);
    cycle(1'b1, 1'b0, 12'h004, 3'd1, 32'h0, 1'b0, 24'h0, 8'h0, rv, iv);
    check(8, "prio after both strobes", rv, 32'h0000_0060);

    // R11: reset in the middle of a run
    do_reset();
    cycle(1'b1, 1'b0, 12'h000, 3'd4, 32'h0, 1'b0, 24'h0, 8'h0, rv, iv);
    check(11, "status after second reset", rv, 32'h0);
    cycle(1'b1, 1'b0, 12'h010, 3'd4, 32'h0, 1'b0, 24'h0, 8'h0, rv, iv);
    check(11, "link 0 after second reset", rv, 32'h0);
    cycle(1'b1, 1'b0, 12'h00C, 3'd1, 32'h0, 1'b0, 24'h0, 8'h0, rv, iv);
    check(11, "request prio after second reset", rv, 32'h0000_00FF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule